// File: doc/BRIEF.md
# EEPROM Image Cache with Checksum Validation

This block holds a local copy of a 64-word, 16-bit configuration EEPROM and answers requests for its contents. It reaches the EEPROM only through a word-level request/done port to a serial master. The pin-level serial protocol belongs to that master and is outside this block. The copy is filled lazily. Every host request first looks at the cached signature field. If that field holds the valid code, the request is served from local registers. Otherwise the whole image is fetched again and checked before the request is served.

An image counts as good when two conditions hold. The 16-bit wrapping sum of all its words must equal 0xBABA. The signature field must hold the valid code. If the sum is wrong, the cached signature is wiped, so every later access fetches the image again. The host can read one word, a 32-bit assembly number or a 6-byte MAC address. It can also write a single word to the EEPROM, or recompute and store the checksum word. Both write operations wipe the cached signature. While a fetch or an update is in progress the block reports busy and does not accept new requests.

Top module: `eeprom_image_cache`

## Requirements
- R1: A fetch reads all 64 words and stores them locally. The image becomes valid only if the 16-bit wrapping sum of the 64 words equals 0xBABA and the signature field holds the valid code.
- R2: The update-checksum request (op code 4) reads words 0 to 62 from the EEPROM. It then writes (0xBABA minus their sum) mod 2^16 to word 63.
- R3: When the sum of a fetched image is not 0xBABA, the cached signature field is cleared. The response then reports invalid (rsp_ok=0), and the next request fetches the image again.
- R4: The signature field is bits 15:14 of word 10. It is masked with 2'b11 and must equal 2'b01. Any other value makes the image invalid even when the sum is correct.
- R5: A read request (op codes 0, 1 and 2) with a valid cached signature issues no EEPROM access. Otherwise it triggers exactly 64 EEPROM reads before the response.
- R6: A word read (op code 0, index in req_addr) returns the cached word. It returns 0 when the index is 64 or more, or when the image is invalid.
- R7: An assembly-number read (op code 1) returns {word 9, word 8} in rsp_data[31:0], or 0 when the image is invalid.
- R8: A MAC read (op code 2) returns {word 2, word 1, word 0} in rsp_data[47:0], which puts address byte 0 (the low byte of word 0) in bits 7:0. It returns 0 when the image is invalid.
- R9: A word write (op code 3) with an index below 64 issues one EEPROM write and clears the cached signature. Its response carries rsp_ok=0 and data 0.
- R10: Once reset has been released, busy is 0, req_ready is 1, and rsp_valid and ee_req are 0. While a fetch, a write or a checksum update is in progress, busy is 1 and req_ready is 0. Each response is a single-cycle rsp_valid pulse.
- R11: A word write with an index of 64 or more issues no EEPROM access and leaves the cached image and its validity unchanged.
- R12: ee_req stays high with ee_addr, ee_we and ee_wdata stable until the cycle in which ee_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request is accepted on a cycle where req_valid and req_ready are both high |
| req_op | input | 3 | Operation: 0 word read, 1 assembly read, 2 MAC read, 3 word write, 4 checksum update |
| req_addr | input | 7 | Word index for read and write (values of 64 and above are out of range) |
| req_wdata | input | 16 | Data for a word write |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_ok | output | 1 | Cached image validity at response time |
| rsp_data | output | 48 | Response data, zero-extended |
| busy | output | 1 | Operation in progress |
| ee_req | output | 1 | Word access request to the serial master |
| ee_we | output | 1 | 1 means write, 0 means read |
| ee_addr | output | 6 | EEPROM word index |
| ee_wdata | output | 16 | Word to write |
| ee_done | input | 1 | One-cycle completion from the master |
| ee_rdata | input | 16 | Read word, valid when ee_done is high |

## Verification
The assertions assume the serial master raises ee_done only while ee_req is high, and only for one cycle per access. The bench's EEPROM model meets this by counting a fixed latency from the request and then pulsing done once, after which it waits for a fresh request. The assertions also assume the host keeps its request stable until it is accepted. The driver task holds req_valid and its fields until it sees req_ready, and it issues only one operation at a time.

// File: rtl/eel_pkg.sv
package eel_pkg;

  typedef enum logic [2:0] {
    OP_RD_WORD = 3'd0,
    OP_RD_ASSY = 3'd1,
    OP_RD_MAC  = 3'd2,
    OP_WR_WORD = 3'd3,
    OP_FIX_SUM = 3'd4
  } eel_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_CHECK,
    ST_WRITE,
    ST_CS_RD,
    ST_CS_WR,
    ST_RESP
  } eel_state_e;

  // Signature field placement inside the cached image
  localparam int          SIG_WORD = 10;
  localparam int          SIG_LSB  = 14;
  localparam int          SIG_W    = 2;
  localparam logic [1:0]  SIG_MASK = 2'b11;
  localparam logic [1:0]  SIG_CODE = 2'b01;

  // Fixed word positions of composite fields
  localparam int ASSY_LO  = 8;
  localparam int ASSY_HI  = 9;
  localparam int MAC_BASE = 0;

  localparam logic [15:0] SUM_TARGET = 16'hBABA;

endpackage

// File: rtl/eel_rst_sync.sv
module eel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/eel_store.sv
module eel_store
  import eel_pkg::*;
#(
  parameter  int WORDS = 64,
  parameter  int DW    = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            clr_sig,
  input  logic [AW-1:0]   rd_idx,
  output logic [DW-1:0]   rd_data,
  output logic            sig_ok,
  output logic [2*DW-1:0] assy,
  output logic [3*DW-1:0] mac
);

  localparam logic [DW-1:0] SIG_FIELD = DW'(SIG_MASK) << SIG_LSB;

  logic [DW-1:0] img [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic          hit_wr;
    logic          hit_clr;
    logic          word_en;
    logic [DW-1:0] word_d;
    logic [DW-1:0] word_q;

    assign hit_wr  = wr_en && (wr_idx == AW'(g));
    if (g == SIG_WORD) begin : g_sig
      assign hit_clr = clr_sig;
    end else begin : g_plain
      assign hit_clr = 1'b0;
    end
    assign word_en = hit_wr || hit_clr;

    always_comb begin
      if (hit_wr) begin
        word_d = wr_data;
      end else begin
        word_d = word_q & ~SIG_FIELD;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign img[g] = word_q;
  end

  assign rd_data = img[rd_idx];
  assign sig_ok  = (img[SIG_WORD][SIG_LSB +: SIG_W] & SIG_MASK) == SIG_CODE;
  assign assy    = {img[ASSY_HI], img[ASSY_LO]};
  assign mac     = {img[MAC_BASE+2], img[MAC_BASE+1], img[MAC_BASE]};

endmodule

// File: rtl/eel_sum.sv
module eel_sum #(
  parameter int            DW     = 16,
  parameter logic [DW-1:0] TARGET = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          add_en,
  input  logic [DW-1:0] addend,
  output logic          match,
  output logic [DW-1:0] fix
);

  logic [DW-1:0] sum_d;
  logic [DW-1:0] sum_q;
  logic          sum_en;

  assign sum_en = clr || add_en;

  always_comb begin
    if (clr) begin
      sum_d = '0;
    end else begin
      sum_d = sum_q + addend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
    end else if (sum_en) begin
      sum_q <= sum_d;
    end
  end

  assign match = (sum_q == TARGET);
  assign fix   = TARGET - sum_q;

endmodule

// File: rtl/eel_ctrl.sv
module eel_ctrl
  import eel_pkg::*;
#(
  parameter  int WORDS = 64,
  parameter  int DW    = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW:0]   req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          sig_ok,
  input  logic          sum_match,
  input  logic [DW-1:0] sum_fix,
  input  logic          ee_done,
  output logic          busy,
  output logic          sum_clr,
  output logic          sum_add,
  output logic          st_wr_en,
  output logic [AW-1:0] st_idx,
  output logic          clr_sig,
  output logic          ee_req,
  output logic          ee_we,
  output logic [AW-1:0] ee_addr,
  output logic [DW-1:0] ee_wdata,
  output logic          rsp_valid,
  output logic [2:0]    op_q,
  output logic [AW:0]   addr_q
);

  eel_state_e    state_q, state_d;
  logic [DW-1:0] data_q;
  logic [AW-1:0] idx_q, idx_d;
  logic          fire;
  logic          step;
  logic          idx_en;
  logic          in_range;
  logic          last_ld;
  logic          last_cs;

  assign fire     = req_valid && (state_q == ST_IDLE);
  assign step     = ee_done && ((state_q == ST_LOAD) || (state_q == ST_CS_RD));
  assign idx_en   = fire || step;
  assign in_range = req_addr < (AW+1)'(WORDS);
  assign last_ld  = idx_q == AW'(WORDS - 1);
  assign last_cs  = idx_q == AW'(WORDS - 2);

  always_comb begin
    state_d = state_q;
    clr_sig = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          case (req_op)
            OP_RD_WORD, OP_RD_ASSY, OP_RD_MAC:
              state_d = sig_ok ? ST_RESP : ST_LOAD;
            OP_WR_WORD:
              state_d = in_range ? ST_WRITE : ST_RESP;
            OP_FIX_SUM:
              state_d = ST_CS_RD;
            default:
              state_d = ST_RESP;
          endcase
        end
      end
      ST_LOAD: begin
        if (ee_done && last_ld) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        clr_sig = !sum_match;
        state_d = ST_RESP;
      end
      ST_WRITE: begin
        if (ee_done) begin
          clr_sig = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_CS_RD: begin
        if (ee_done && last_cs) state_d = ST_CS_WR;
      end
      ST_CS_WR: begin
        if (ee_done) begin
          clr_sig = 1'b1;
          state_d = ST_RESP;
        end
      end
      ST_RESP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    if (fire) begin
      idx_d = '0;
    end else begin
      idx_d = idx_q + AW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      op_q   <= req_op;
      addr_q <= req_addr;
      data_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  always_comb begin
    ee_req   = 1'b0;
    ee_we    = 1'b0;
    ee_addr  = '0;
    ee_wdata = '0;
    case (state_q)
      ST_LOAD, ST_CS_RD: begin
        ee_req  = 1'b1;
        ee_addr = idx_q;
      end
      ST_WRITE: begin
        ee_req   = 1'b1;
        ee_we    = 1'b1;
        ee_addr  = addr_q[AW-1:0];
        ee_wdata = data_q;
      end
      ST_CS_WR: begin
        ee_req   = 1'b1;
        ee_we    = 1'b1;
        ee_addr  = AW'(WORDS - 1);
        ee_wdata = sum_fix;
      end
      default: ;
    endcase
  end

  assign busy      = state_q != ST_IDLE;
  assign sum_clr   = fire;
  assign sum_add   = step;
  assign st_wr_en  = ee_done && (state_q == ST_LOAD);
  assign st_idx    = idx_q;
  assign rsp_valid = state_q == ST_RESP;

endmodule

// File: rtl/eeprom_image_cache.sv
module eeprom_image_cache
  import eel_pkg::*;
#(
  parameter  int WORDS = 64,
  parameter  int DW    = 16,
  localparam int AW    = $clog2(WORDS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic [AW:0]     req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic            rsp_valid,
  output logic            rsp_ok,
  output logic [3*DW-1:0] rsp_data,
  output logic            busy,
  output logic            ee_req,
  output logic            ee_we,
  output logic [AW-1:0]   ee_addr,
  output logic [DW-1:0]   ee_wdata,
  input  logic            ee_done,
  input  logic [DW-1:0]   ee_rdata
);

  logic            rst_n_s;
  logic            sig_ok;
  logic            sum_match;
  logic [DW-1:0]   sum_fix;
  logic            sum_clr;
  logic            sum_add;
  logic            st_wr_en;
  logic [AW-1:0]   st_idx;
  logic            clr_sig;
  logic [2:0]      op_q;
  logic [AW:0]     addr_q;
  logic [DW-1:0]   rd_data;
  logic [2*DW-1:0] assy;
  logic [3*DW-1:0] mac;
  logic            addr_ok;

  eel_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  eel_ctrl #(.WORDS(WORDS), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .sig_ok    (sig_ok),
    .sum_match (sum_match),
    .sum_fix   (sum_fix),
    .ee_done   (ee_done),
    .busy      (busy),
    .sum_clr   (sum_clr),
    .sum_add   (sum_add),
    .st_wr_en  (st_wr_en),
    .st_idx    (st_idx),
    .clr_sig   (clr_sig),
    .ee_req    (ee_req),
    .ee_we     (ee_we),
    .ee_addr   (ee_addr),
    .ee_wdata  (ee_wdata),
    .rsp_valid (rsp_valid),
    .op_q      (op_q),
    .addr_q    (addr_q)
  );

  eel_store #(.WORDS(WORDS), .DW(DW)) u_store (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .wr_en   (st_wr_en),
    .wr_idx  (st_idx),
    .wr_data (ee_rdata),
    .clr_sig (clr_sig),
    .rd_idx  (addr_q[AW-1:0]),
    .rd_data (rd_data),
    .sig_ok  (sig_ok),
    .assy    (assy),
    .mac     (mac)
  );

  eel_sum #(.DW(DW), .TARGET(DW'(SUM_TARGET))) u_sum (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .clr    (sum_clr),
    .add_en (sum_add),
    .addend (ee_rdata),
    .match  (sum_match),
    .fix    (sum_fix)
  );

  assign addr_ok   = addr_q < (AW+1)'(WORDS);
  assign req_ready = !busy;
  assign rsp_ok    = sig_ok;

  always_comb begin
    rsp_data = '0;
    if (sig_ok) begin
      case (op_q)
        OP_RD_WORD: if (addr_ok) rsp_data = {{(2*DW){1'b0}}, rd_data};
        OP_RD_ASSY: rsp_data = {{DW{1'b0}}, assy};
        OP_RD_MAC:  rsp_data = mac;
        default:    rsp_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/eel_checker.sv
module eel_checker #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            ee_req,
  input logic            ee_we,
  input logic [AW-1:0]   ee_addr,
  input logic [DW-1:0]   ee_wdata,
  input logic            ee_done,
  input logic            rsp_valid,
  input logic            rsp_ok,
  input logic [3*DW-1:0] rsp_data
);

  // R12: an open access keeps its request and fields until completion
  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && !ee_done) |=> (ee_req && $stable(ee_addr) && $stable(ee_we) && $stable(ee_wdata)));

  // R6: an invalid image never returns data
  p_rsp_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ok) |-> (rsp_data == '0));

  // R10: no EEPROM traffic while idle
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !ee_req);

  // R10: responses are single-cycle pulses
  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R9: a completed EEPROM write is answered at once with the cache invalid
  p_write_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_req && ee_we && ee_done) |=> (rsp_valid && !rsp_ok));

endmodule

bind eeprom_image_cache eel_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .ee_req    (ee_req),
  .ee_we     (ee_we),
  .ee_addr   (ee_addr),
  .ee_wdata  (ee_wdata),
  .ee_done   (ee_done),
  .rsp_valid (rsp_valid),
  .rsp_ok    (rsp_ok),
  .rsp_data  (rsp_data)
);

// File: tb/tb_eeprom_image_cache.sv
`timescale 1ns/100ps
module tb_eeprom_image_cache;

  localparam int LAT = 3;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [2:0]  req_op;
  logic [6:0]  req_addr;
  logic [15:0] req_wdata;
  logic        rsp_valid;
  logic        rsp_ok;
  logic [47:0] rsp_data;
  logic        busy;
  logic        ee_req;
  logic        ee_we;
  logic [5:0]  ee_addr;
  logic [15:0] ee_wdata;
  logic        ee_done;
  logic [15:0] ee_rdata;

  int checks = 0;
  int errors = 0;

  eeprom_image_cache dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_data(rsp_data),
    .busy(busy), .ee_req(ee_req), .ee_we(ee_we), .ee_addr(ee_addr),
    .ee_wdata(ee_wdata), .ee_done(ee_done), .ee_rdata(ee_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- EEPROM model behind the serial master ----------------
  logic [15:0] emem [64];
  int          n_rd = 0;
  int          n_wr = 0;
  int          hs_err = 0;
  int          wcnt = 0;
  logic [5:0]  lat_addr;
  logic        lat_we;

  always @(posedge clk) begin
    if (!rst_n) begin
      ee_done  <= 1'b0;
      ee_rdata <= '0;
      wcnt     <= 0;
    end else if (ee_done) begin
      ee_done <= 1'b0;
    end else if (ee_req) begin
      if (wcnt == 0) begin
        lat_addr <= ee_addr;
        lat_we   <= ee_we;
      end else if (ee_addr != lat_addr || ee_we != lat_we) begin
        hs_err <= hs_err + 1;
      end
      if (wcnt == LAT - 1) begin
        wcnt    <= 0;
        ee_done <= 1'b1;
        if (ee_we) begin
          emem[ee_addr] <= ee_wdata;
          n_wr <= n_wr + 1;
        end else begin
          ee_rdata <= emem[ee_addr];
          n_rd <= n_rd + 1;
        end
      end else begin
        wcnt <= wcnt + 1;
      end
    end
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [47:0] data;
    logic        ok;
    string       tag;
  } exp_t;

  exp_t exq[$];

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      checks++;
      if (exq.size() == 0) begin
        errors++;
        $display("FAIL unexpected response: data=%h ok=%0b expected none", rsp_data, rsp_ok);
      end else begin
        exp_t e;
        e = exq.pop_front();
        if (rsp_data !== e.data || rsp_ok !== e.ok) begin
          errors++;
          $display("FAIL %s: data=%h ok=%0b expected data=%h ok=%0b",
                   e.tag, rsp_data, rsp_ok, e.data, e.ok);
        end
      end
    end
  end

  task automatic check(input bit cond, input string tag, input longint act, input longint expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // Bench-side view of the cache
  logic [15:0] bc [64];
  bit          bv = 0;

  function automatic logic [15:0] sum_range(input int n);
    logic [15:0] s = 16'h0;
    for (int i = 0; i < n; i++) s = s + emem[i];
    return s;
  endfunction

  task automatic do_op(input logic [2:0] op, input int addr, input logic [15:0] wd, input string tag);
    exp_t        e;
    int          rd0 = n_rd;
    int          wr0 = n_wr;
    int          erd = 0;
    int          ewr = 0;
    logic [15:0] exp63 = 16'h0;
    e.data = '0;
    e.ok   = 1'b0;
    e.tag  = tag;
    if (op <= 3'd2) begin
      if (!bv) begin
        logic [15:0] s = 16'h0;
        for (int i = 0; i < 64; i++) begin
          bc[i] = emem[i];
          s = s + emem[i];
        end
        if (s != 16'hBABA) bc[10][15:14] = 2'b00;
        bv  = (bc[10][15:14] == 2'b01);
        erd = 64;
      end
      e.ok = bv;
      if (bv) begin
        case (op)
          3'd0: e.data = (addr < 64) ? {32'h0, bc[addr]} : 48'h0;
          3'd1: e.data = {16'h0, bc[9], bc[8]};
          default: e.data = {bc[2], bc[1], bc[0]};
        endcase
      end
    end else if (op == 3'd3) begin
      if (addr < 64) begin
        ewr = 1;
        bv  = 0;
        e.ok = 1'b0;
      end else begin
        e.ok = bv;
      end
    end else begin
      exp63 = 16'hBABA - sum_range(63);
      erd = 63;
      ewr = 1;
      bv  = 0;
    end
    exq.push_back(e);

    @(negedge clk);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = 7'(addr);
    req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (erd > 0 || ewr > 0)
      check(busy && !req_ready, {tag, " R10 stall while busy"}, {busy, req_ready}, 2'b10);
    while (exq.size() != 0) @(negedge clk);
    @(negedge clk);
    check(n_rd - rd0 == erd, {tag, " R5 EEPROM read count"}, n_rd - rd0, erd);
    check(n_wr - wr0 == ewr, {tag, " R11 EEPROM write count"}, n_wr - wr0, ewr);
    if (op == 3'd3 && addr < 64)
      check(emem[addr] == wd, {tag, " R9 stored word"}, emem[addr], wd);
    if (op == 3'd4)
      check(emem[63] == exp63, {tag, " R2 checksum word"}, emem[63], exp63);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    req_valid = 1'b0;
    req_op    = '0;
    req_addr  = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    for (int i = 0; i < 64; i++) emem[i] = 16'(i * 16'h0713 + 16'h2A41);
    emem[10] = (emem[10] & 16'h3FFF) | 16'h4000;
    emem[63] = 16'hBABA - sum_range(63);

    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && req_ready && !rsp_valid && !ee_req, "R10 reset state",
          {busy, req_ready, rsp_valid, ee_req}, 4'b0100);

    do_op(3'd0, 5, 16'h0, "R1 first read fetches image");
    do_op(3'd0, 5, 16'h0, "R5 cached read, no fetch");
    do_op(3'd1, 0, 16'h0, "R7 assembly number");
    do_op(3'd2, 0, 16'h0, "R8 MAC address");
    do_op(3'd0, 64, 16'h0, "R6 index 64 reads zero");
    do_op(3'd0, 63, 16'h0, "R6 last word");
    do_op(3'd3, 70, 16'hFFFF, "R11 out-of-range write ignored");
    do_op(3'd0, 2, 16'h0, "R11 cache still valid");
    do_op(3'd3, 3, 16'h1234, "R9 word write");
    do_op(3'd0, 3, 16'h0, "R3 bad checksum reads zero");
    do_op(3'd1, 0, 16'h0, "R3 refetch, assembly zero");
    do_op(3'd4, 0, 16'h0, "R2 checksum update");
    do_op(3'd0, 3, 16'h0, "R1 refetch after fix");
    do_op(3'd3, 10, (emem[10] & 16'h3FFF) | 16'h8000, "R4 corrupt signature");
    do_op(3'd4, 0, 16'h0, "R2 checksum update again");
    do_op(3'd0, 0, 16'h0, "R4 bad signature reads zero");
    do_op(3'd2, 0, 16'h0, "R8 MAC zero when invalid");
    do_op(3'd3, 10, (emem[10] & 16'h3FFF) | 16'h4000, "R4 restore signature");
    do_op(3'd4, 0, 16'h0, "R2 checksum restore");
    do_op(3'd2, 0, 16'h0, "R8 MAC after restore");
    do_op(3'd1, 0, 16'h0, "R7 assembly cached");

    check(hs_err == 0, "R12 request held stable until done", hs_err, 0);
    check(exq.size() == 0, "R10 all responses seen", exq.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule